// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is a register-driven engine for single-lane SPI flash transactions in mode 3. Software first loads a 24-bit address register and a 32-bit data register. It then writes a command word, and that write starts a run of byte phases on the serial pins. The phases are an opcode byte, 0 to 3 address bytes, 0 to 15 dummy bytes, and 0 to 4 data bytes. The data bytes are either shifted out of the data register or shifted into it.

A status register shows whether a command is still in flight. It also holds a sticky error flag. A timing register sets the length of each serial bit in core clock cycles, and the cycles within that bit at which SCK falls, SCK rises and MISO is sampled.

One flash transaction can span several commands through the keep-selected bit. While chip select is held from an earlier command, the next command omits its opcode byte and continues with its address, dummy or data bytes. A command with no bytes at all and keep-selected clear only releases chip select.

Top module: `sfc_cmd_seq`

## Requirements
- R1: The bus selects registers by word index: 0 = command (write only; a write starts a command), 1 = address (bits 23:0, read back with upper bits zero), 2 = data, 3 = status, 4 = timing (bits 19:0 read back). The command word has these fields: opcode in bits 7:0, write direction in bit 8 (1 = write), data length in bits 11:9, keep-selected in bit 15, dummy length in bits 19:16, address length in bits 22:20, chip select index in bits 26:24.
- R2: When chip select is not already held, the first byte on MOSI is the opcode, sent most significant bit first. When chip select is held from an earlier keep-selected command, no opcode byte is sent.
- R3: After the opcode come address-length bytes taken from the address register, most significant byte first. For example, a length of 2 sends bits 15:8 and then bits 7:0. Lengths above 3 are treated as 3.
- R4: After the address come dummy-length bytes (0 to 15), each of which drives MOSI to zero.
- R5: A write command then sends data-length bytes from the data register, byte k taken from bits 8k+7:8k, byte 0 first, each byte sent most significant bit first. Data-length values 5 to 7 are treated as 4. A write leaves the data register unchanged.
- R6: A read command drives MOSI to zero during its data bytes. The k-th received byte (its first bit received is its most significant bit) is stored in bits 8k+7:8k of the data register, and bytes that were not received read as zero. The data register is updated no later than the cycle in which the pending flag clears. A read with data length 0 leaves the data register unchanged.
- R7: When keep-selected is 1, chip select stays asserted after the command ends. When keep-selected is 0, chip select is released. A command issued while chip select is held, with every length zero and keep-selected 0, produces no SCK edges and releases chip select.
- R8: Status bit 22 (pending) reads 1 from the cycle after a command write until the command completes, and 0 otherwise.
- R9: A command write that arrives while pending is 1 is ignored: no extra bytes are sent. It sets status bit 29 (error). Bit 29 is cleared by writing status with bit 29 = 1, and writing status with bit 29 = 0 leaves it set.
- R10: SCK idles high. MOSI changes only on a falling SCK edge, and the slave samples it on the rising edge. Timing register fields are: bit period P in bits 3:0, rise position in bits 11:8, fall position in bits 15:12, MISO sample position in bits 19:16, all in core cycles. Consecutive falling edges within a command are exactly P cycles apart. P = 0 behaves as P = 2.
- R11: The chip select index field n drives line cs_no[n] low and every other line stays high. At most one line is low at any time.
- R12: After reset, SCK is high, all chip selects are high, MOSI is 0, and the status, address, data and timing registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_idx_i | input | 3 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_idx_i (combinational) |
| sck_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |
| cs_no | output | CS_LINES | Chip selects, active low |

## Verification
The assertions assume the following about the inputs: the timing register is programmed with fall < rise <= sample < P and P >= 2 (or 0); address, data and timing are not rewritten while a command is pending; and MISO is stable at the sample position. The bench honours all of these. It changes timing only between commands, and it uses only the orderings 0/1/1 with period 2 (or 0) and 1/3/4 with period 5. Its slave model presents each MISO bit on the falling SCK edge, well before the sample point. It polls the pending flag before touching any other register. The only write it issues during a pending command is the deliberate second command word that exercises the error path.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int REG_CMD  = 0;
  localparam int REG_ADDR = 1;
  localparam int REG_DATA = 2;
  localparam int REG_STAT = 3;
  localparam int REG_TIM  = 4;

  localparam int OPC_LSB  = 0;
  localparam int DIR_BIT  = 8;
  localparam int DLEN_LSB = 9;
  localparam int KEEP_BIT = 15;
  localparam int DUM_LSB  = 16;
  localparam int ALEN_LSB = 20;
  localparam int CS_LSB   = 24;

  localparam int PEND_BIT = 22;
  localparam int ERR_BIT  = 29;

  localparam int PER_LSB  = 0;
  localparam int RISE_LSB = 8;
  localparam int FALL_LSB = 12;
  localparam int SMP_LSB  = 16;
  localparam int TIM_W    = 20;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_END} seq_st_e;
  typedef enum logic [2:0] {PH_OPC, PH_ADDR, PH_DUM, PH_DATA, PH_NONE} phase_e;

  typedef struct packed {
    logic [2:0] cs;
    logic       keep;
    logic [3:0] dum;
    logic [1:0] alen;
    logic [2:0] dlen;
    logic       wr;
    logic [7:0] opc;
  } cmd_t;

  // next non-empty phase after p
  function automatic phase_e next_ph(phase_e p, cmd_t c);
    logic a, d, x;
    a = (c.alen != 2'd0);
    d = (c.dum != 4'd0);
    x = (c.dlen != 3'd0);
    case (p)
      PH_OPC:  return a ? PH_ADDR : d ? PH_DUM : x ? PH_DATA : PH_NONE;
      PH_ADDR: return d ? PH_DUM : x ? PH_DATA : PH_NONE;
      PH_DUM:  return x ? PH_DATA : PH_NONE;
      default: return PH_NONE;
    endcase
  endfunction

  function automatic logic [3:0] ph_len(phase_e p, cmd_t c);
    case (p)
      PH_OPC:  return 4'd1;
      PH_ADDR: return {2'b00, c.alen};
      PH_DUM:  return c.dum;
      PH_DATA: return {1'b0, c.dlen};
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/sfc_sck_gen.sv
module sfc_sck_gen #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] rise_i,
  input  logic [CNT_W-1:0] fall_i,
  input  logic [CNT_W-1:0] smp_i,
  output logic             sck_o,
  output logic             fall_o,
  output logic             smp_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_m1;

  // period 0 runs as 2 so SCK never stalls
  assign per_m1 = (per_i == '0) ? CNT_W'(1) : per_i - 1'b1;
  assign last_o = run_i && (cnt_q == per_m1);
  assign fall_o = run_i && (cnt_q == fall_i);
  assign smp_o  = run_i && (cnt_q == smp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_o <= 1'b1;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_o <= 1'b1;
    end else begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
      if (fall_o)                sck_o <= 1'b0;
      else if (cnt_q == rise_i)  sck_o <= 1'b1;
    end
  end

  AST_CELL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && run_i |=> !run_i || cnt_q == '0); // R10
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  cmd_t        cmd_i,
  input  logic [23:0] addr_i,
  input  logic [31:0] wdata_i,
  input  logic        miso_i,
  input  logic        sck_i,
  input  logic        fall_i,
  input  logic        smp_i,
  input  logic        last_i,
  output logic        run_o,
  output logic        mosi_o,
  output logic        cs_on_o,
  output logic [2:0]  cs_sel_o,
  output logic        done_o,
  output logic        rd_done_o,
  output logic [31:0] rdata_o
);
  seq_st_e     st_q;
  phase_e      ph_q, ph_nxt, ph_first;
  cmd_t        cmd_q;
  logic [3:0]  left_q;
  logic [2:0]  bit_q;
  logic [1:0]  dbyte_q;
  logic [23:0] ash_q;
  logic [7:0]  rx_q, rx_nxt, cur_byte;
  logic [31:0] rbuf_q;
  logic        mosi_q, cs_on_q;
  logic [2:0]  cs_sel_q;
  logic        unused_seq;

  assign ph_nxt   = next_ph(ph_q, cmd_q);
  assign ph_first = cs_on_q ? next_ph(PH_OPC, cmd_i) : PH_OPC;
  assign rx_nxt   = smp_i ? {rx_q[6:0], miso_i} : rx_q;

  always_comb begin
    case (ph_q)
      PH_OPC:  cur_byte = cmd_q.opc;
      PH_ADDR: cur_byte = ash_q[23:16];
      PH_DATA: cur_byte = cmd_q.wr ? wdata_i[8*dbyte_q +: 8] : 8'h00;
      default: cur_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ph_q     <= PH_NONE;
      cmd_q    <= '0;
      left_q   <= '0;
      bit_q    <= '0;
      dbyte_q  <= '0;
      ash_q    <= '0;
      rx_q     <= '0;
      rbuf_q   <= '0;
      mosi_q   <= 1'b0;
      cs_on_q  <= 1'b0;
      cs_sel_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          cmd_q   <= cmd_i;
          ash_q   <= addr_i << {2'd3 - cmd_i.alen, 3'b000};
          dbyte_q <= '0;
          bit_q   <= '0;
          rbuf_q  <= '0;
          ph_q    <= ph_first;
          left_q  <= ph_len(ph_first, cmd_i);
          st_q    <= (ph_first == PH_NONE) ? ST_END : ST_SHIFT;
          if (!cs_on_q) begin
            cs_on_q  <= 1'b1;
            cs_sel_q <= cmd_i.cs;
          end
        end
        ST_SHIFT: begin
          rx_q <= rx_nxt;
          if (fall_i) mosi_q <= cur_byte[3'd7 - bit_q];
          if (last_i) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q == 3'd7) begin
              if (ph_q == PH_ADDR) ash_q <= ash_q << 8;
              if (ph_q == PH_DATA) begin
                if (!cmd_q.wr) rbuf_q[8*dbyte_q +: 8] <= rx_nxt;
                dbyte_q <= dbyte_q + 1'b1;
              end
              if (left_q == 4'd1) begin
                ph_q   <= ph_nxt;
                left_q <= ph_len(ph_nxt, cmd_q);
                if (ph_nxt == PH_NONE) st_q <= ST_END;
              end else begin
                left_q <= left_q - 1'b1;
              end
            end
          end
        end
        default: begin
          st_q <= ST_IDLE;
          if (!cmd_q.keep) cs_on_q <= 1'b0;
        end
      endcase
    end
  end

  assign run_o     = (st_q == ST_SHIFT);
  assign mosi_o    = mosi_q;
  assign cs_on_o   = cs_on_q;
  assign cs_sel_o  = cs_sel_q;
  assign done_o    = (st_q == ST_END);
  assign rd_done_o = done_o && !cmd_q.wr && (cmd_q.dlen != 3'd0);
  assign rdata_o   = rbuf_q;
  assign unused_seq = ^cmd_q.cs;

  AST_MOSI_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_q) |-> !sck_i); // R10
  AST_HELD_SKIPS_OPC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && cs_on_q |=> ph_q != PH_OPC); // R2
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> st_q == ST_IDLE); // R9
endmodule

// File: rtl/sfc_cmd_seq.sv
module sfc_cmd_seq
  import sfc_pkg::*;
#(
  parameter int unsigned CS_LINES = 8,
  parameter int unsigned CNT_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_sel_i,
  input  logic                bus_we_i,
  input  logic [2:0]          bus_idx_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic                sck_o,
  output logic                mosi_o,
  input  logic                miso_i,
  output logic [CS_LINES-1:0] cs_no
);
  logic [23:0]      addr_q;
  logic [31:0]      data_q;
  logic [TIM_W-1:0] tim_q;
  logic             pend_q, err_q;
  logic             wr_cmd, start;
  cmd_t             cmd_w;
  logic [2:0]       dl_raw, al_raw;
  logic             run, fall_p, smp_p, last_p;
  logic             seq_done, rd_done, cs_on;
  logic [2:0]       cs_sel;
  logic [31:0]      seq_rdata;
  logic             unused_bus;

  assign wr_cmd = bus_sel_i && bus_we_i && (bus_idx_i == 3'(REG_CMD));
  assign start  = wr_cmd && !pend_q;
  assign unused_bus = ^bus_wdata_i;

  always_comb begin
    dl_raw     = bus_wdata_i[DLEN_LSB +: 3];
    al_raw     = bus_wdata_i[ALEN_LSB +: 3];
    cmd_w.opc  = bus_wdata_i[OPC_LSB +: 8];
    cmd_w.wr   = bus_wdata_i[DIR_BIT];
    cmd_w.dlen = (dl_raw > 3'd4) ? 3'd4 : dl_raw;
    cmd_w.alen = (al_raw > 3'd3) ? 2'd3 : al_raw[1:0];
    cmd_w.dum  = bus_wdata_i[DUM_LSB +: 4];
    cmd_w.keep = bus_wdata_i[KEEP_BIT];
    cmd_w.cs   = bus_wdata_i[CS_LSB +: 3];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      data_q <= '0;
      tim_q  <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (bus_sel_i && bus_we_i) begin
        case (bus_idx_i)
          3'(REG_ADDR): addr_q <= bus_wdata_i[23:0];
          3'(REG_DATA): data_q <= bus_wdata_i;
          3'(REG_STAT): if (bus_wdata_i[ERR_BIT]) err_q <= 1'b0;
          3'(REG_TIM):  tim_q  <= bus_wdata_i[TIM_W-1:0];
          default: ;
        endcase
      end
      if (wr_cmd && pend_q) err_q <= 1'b1;
      if (rd_done) data_q <= seq_rdata;
      if (start)         pend_q <= 1'b1;
      else if (seq_done) pend_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_idx_i)
      3'(REG_ADDR): bus_rdata_o = {8'h00, addr_q};
      3'(REG_DATA): bus_rdata_o = data_q;
      3'(REG_STAT): begin
        bus_rdata_o[PEND_BIT] = pend_q;
        bus_rdata_o[ERR_BIT]  = err_q;
      end
      3'(REG_TIM):  bus_rdata_o[TIM_W-1:0] = tim_q;
      default: ;
    endcase
  end

  sfc_sck_gen #(.CNT_W(CNT_W)) u_sck (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .per_i  (tim_q[PER_LSB +: CNT_W]),
    .rise_i (tim_q[RISE_LSB +: CNT_W]),
    .fall_i (tim_q[FALL_LSB +: CNT_W]),
    .smp_i  (tim_q[SMP_LSB +: CNT_W]),
    .sck_o  (sck_o),
    .fall_o (fall_p),
    .smp_o  (smp_p),
    .last_o (last_p)
  );

  sfc_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cmd_i     (cmd_w),
    .addr_i    (addr_q),
    .wdata_i   (data_q),
    .miso_i    (miso_i),
    .sck_i     (sck_o),
    .fall_i    (fall_p),
    .smp_i     (smp_p),
    .last_i    (last_p),
    .run_o     (run),
    .mosi_o    (mosi_o),
    .cs_on_o   (cs_on),
    .cs_sel_o  (cs_sel),
    .done_o    (seq_done),
    .rd_done_o (rd_done),
    .rdata_o   (seq_rdata)
  );

  for (genvar g = 0; g < CS_LINES; g++) begin : g_cs
    assign cs_no[g] = !(cs_on && (32'(cs_sel) == g));
  end

  AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !seq_done |=> pend_q); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done |=> !pend_q); // R8
  AST_BUSY_WRITE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd && pend_q |=> err_q); // R9
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &cs_no |-> sck_o); // R10
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no)); // R11
  AST_READ_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done |=> data_q == $past(seq_rdata)); // R6
endmodule

// File: tb/sim_sfc_cmd_seq.sv
module sim_sfc_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CS_LINES   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [2:0] idx = '0;
  logic [31:0] wdata = '0, rdata;
  logic sck, mosi, miso = 1'b0;
  logic [CS_LINES-1:0] cs_n;
  logic cs_any;

  always #(CLK_PERIOD/2) clk = ~clk;

  sfc_cmd_seq #(.CS_LINES(CS_LINES), .CNT_W(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_idx_i(idx), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic cap [0:1023];
  logic expb [0:1023];
  int ncap = 0, nexp = 0, sbit = 0;
  int pf = -1, gmin = 9999, gmax = 0;

  assign cs_any = ~&cs_n;
  always @(posedge clk) cyc++;

  function automatic logic [7:0] fb(int j);
    return 8'(32'h5A + j * 39);
  endfunction

  // slave model: new stream on select, drive on fall, capture on rise
  always @(posedge cs_any) sbit = 0;
  always @(negedge sck) if (cs_any) begin
    logic [7:0] b;
    b = fb(sbit / 8);
    miso = b[7 - (sbit % 8)];
    sbit++;
    if (pf >= 0) begin
      if (cyc - pf < gmin) gmin = cyc - pf;
      if (cyc - pf > gmax) gmax = cyc - pf;
    end
    pf = cyc;
  end
  always @(posedge sck) if (cs_any && ncap < 1024) begin
    cap[ncap] = mosi;
    ncap++;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic bus_wr(input int i, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; idx = 3'(i); wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input int i, output logic [31:0] d);
    @(negedge clk);
    idx = 3'(i);
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 10000; k++) begin
      bus_rd(3, s);
      if (!s[22]) break;
    end
  endtask

  task automatic clr_cap();
    ncap = 0; pf = -1; gmin = 9999; gmax = 0;
  endtask

  function automatic logic [31:0] mk(int opc, int wr, int dlen, int keep, int dum, int alen, int cs);
    return {5'b0, 3'(cs), 1'b0, 3'(alen), 4'(dum), 1'(keep), 3'b0, 3'(dlen), 1'(wr), 8'(opc)};
  endfunction

  task automatic push_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      expb[nexp] = b[i];
      nexp++;
    end
  endtask

  task automatic build(input bit skip, input logic [7:0] opc, input int alen, input logic [23:0] addr,
                       input int dum, input int dlen, input bit wr, input logic [31:0] data);
    nexp = 0;
    if (!skip) push_byte(opc);
    for (int k = 0; k < alen; k++) push_byte(8'(addr >> (8 * (alen - 1 - k))));
    for (int k = 0; k < dum; k++) push_byte(8'h00);
    for (int k = 0; k < dlen; k++) push_byte(wr ? 8'(data >> (8 * k)) : 8'h00);
  endtask

  task automatic cmp_stream(input string tag);
    logic ok;
    ok = 1'b1;
    chk(ncap == nexp, {tag, " bit count"}, 32'(ncap), 32'(nexp));
    for (int i = 0; i < nexp; i++) if (cap[i] !== expb[i]) ok = 1'b0;
    chk(ok, {tag, " bit values"}, 32'(ok), 32'd1);
  endtask

  function automatic logic [31:0] rd_exp(int base, int dlen);
    logic [31:0] e;
    e = '0;
    for (int k = 0; k < dlen; k++) e |= 32'(fb(base + k)) << (8 * k);
    return e;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act=%0h exp=%0h", 0, 1);
    summary();
  end

  initial begin
    logic [31:0] d;
    int i;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(sck === 1'b1, "R12 sck idle", 32'(sck), 1);
    chk(cs_n === '1, "R12 cs idle", 32'(cs_n), 32'hFF);
    chk(mosi === 1'b0, "R12 mosi", 32'(mosi), 0);
    rst_n = 1'b1;
    bus_rd(3, d); chk(d == 0, "R12 status", d, 0);
    bus_rd(2, d); chk(d == 0, "R12 data", d, 0);
    bus_rd(1, d); chk(d == 0, "R12 addr", d, 0);
    bus_rd(4, d); chk(d == 0, "R12 timing", d, 0);

    // R1 readback
    bus_wr(1, 32'hFFABCDEF); bus_rd(1, d); chk(d == 32'h00ABCDEF, "R1 addr readback", d, 32'h00ABCDEF);
    bus_wr(4, 32'hFFF10102); bus_rd(4, d); chk(d == 32'h00010102, "R1 timing readback", d, 32'h00010102);

    // sweep: P=2 fall0 rise1 sample1
    bus_wr(4, 32'h00010102);
    i = 0;
    for (int alen = 0; alen < 4; alen++)
      for (int di = 0; di < 2; di++)
        for (int dlen = 0; dlen < 5; dlen++)
          for (int wr = 0; wr < 2; wr++) begin
            logic [23:0] a;
            logic [31:0] dv, e;
            int dum;
            dum = di * 2;
            a  = 24'(32'hC3A5E1 + i * 32'h10307);
            dv = 32'h8E3D71B4 ^ 32'(i * 32'h01030507);
            bus_wr(1, {8'h00, a});
            bus_wr(2, dv);
            clr_cap();
            bus_wr(0, mk(8'h10 + i, wr, dlen, 0, dum, alen, 0));
            wait_idle();
            build(1'b0, 8'(8'h10 + i), alen, a, dum, dlen, wr[0], dv);
            cmp_stream("R2/R3/R4/R5 sweep");
            bus_rd(2, d);
            e = (wr == 1 || dlen == 0) ? dv : rd_exp(1 + alen + dum, dlen);
            chk(d == e, "R5/R6 data register", d, e);
            chk(cs_n === '1, "R7 released", 32'(cs_n), 32'hFF);
            chk(gmin == 2 && gmax == 2, "R10 period 2", 32'(gmax), 2);
            i++;
          end

    // R5 length field 7 acts as 4; R4 fifteen dummies
    bus_wr(1, 32'h00123456); bus_wr(2, 32'hA1B2C3D4);
    clr_cap(); bus_wr(0, mk(8'h02, 1, 7, 0, 15, 1, 0)); wait_idle();
    build(1'b0, 8'h02, 1, 24'h123456, 15, 4, 1'b1, 32'hA1B2C3D4);
    cmp_stream("R4/R5 dlen7 dum15");

    // R10 P=5 fall1 rise3 sample4 with read
    bus_wr(4, 32'h00041305);
    clr_cap(); bus_wr(0, mk(8'h03, 0, 2, 0, 0, 1, 0)); wait_idle();
    build(1'b0, 8'h03, 1, 24'h123456, 0, 2, 1'b0, 0);
    cmp_stream("R10 period5");
    chk(gmin == 5 && gmax == 5, "R10 period 5 gap", 32'(gmax), 5);
    bus_rd(2, d); chk(d == rd_exp(2, 2), "R6 read at P5", d, rd_exp(2, 2));

    // R10 period field 0
    bus_wr(4, 32'h00010100);
    clr_cap(); bus_wr(0, mk(8'h05, 0, 1, 0, 0, 0, 0)); wait_idle();
    chk(gmin == 2 && gmax == 2, "R10 period 0 as 2", 32'(gmax), 2);
    bus_wr(4, 32'h00010102);

    // R7/R2 chained commands
    bus_wr(1, 32'h00ABCDEF);
    clr_cap(); bus_wr(0, mk(8'h0B, 0, 0, 1, 1, 3, 0));
    bus_rd(3, d); chk(d[22] == 1'b1, "R8 pending set", d, 32'h00400000);
    wait_idle();
    bus_rd(3, d); chk(d[22] == 1'b0, "R8 pending clear", d, 0);
    build(1'b0, 8'h0B, 3, 24'hABCDEF, 1, 0, 1'b0, 0);
    cmp_stream("R7 chain head");
    chk(cs_n === 8'hFE, "R7 held", 32'(cs_n), 32'hFE);
    bus_wr(2, 32'h00005A3C);
    clr_cap(); bus_wr(0, mk(8'hEE, 1, 2, 1, 0, 0, 0)); wait_idle();
    build(1'b1, 8'h00, 0, 0, 0, 2, 1'b1, 32'h00005A3C);
    cmp_stream("R2 opcode skipped");
    clr_cap(); bus_wr(0, mk(8'hEE, 0, 3, 0, 0, 0, 0)); wait_idle();
    build(1'b1, 8'h00, 0, 0, 0, 3, 1'b0, 0);
    cmp_stream("R2 chain read");
    bus_rd(2, d); chk(d == rd_exp(7, 3), "R6 chain read data", d, rd_exp(7, 3));
    chk(cs_n === '1, "R7 chain released", 32'(cs_n), 32'hFF);

    // R7 release-only command; R11 select line 2
    bus_wr(2, 32'h77);
    clr_cap(); bus_wr(0, mk(8'h06, 1, 0, 1, 0, 0, 2)); wait_idle();
    chk(cs_n === 8'hFB, "R11 line 2 low", 32'(cs_n), 32'hFB);
    clr_cap(); bus_wr(0, mk(8'h99, 0, 0, 0, 0, 0, 5)); wait_idle();
    chk(ncap == 0, "R7 release no sck", 32'(ncap), 0);
    chk(cs_n === '1, "R7 release only", 32'(cs_n), 32'hFF);

    // R9 command while busy
    clr_cap();
    bus_wr(0, mk(8'h3C, 0, 4, 0, 0, 0, 0));
    bus_wr(0, mk(8'hC3, 1, 4, 0, 0, 3, 0));
    bus_rd(3, d); chk(d[29] == 1'b1, "R9 error set", d, 32'h20400000);
    wait_idle();
    build(1'b0, 8'h3C, 0, 0, 0, 4, 1'b0, 0);
    cmp_stream("R9 second write ignored");
    bus_wr(3, 32'h0); bus_rd(3, d); chk(d[29] == 1'b1, "R9 write 0 keeps error", d, 32'h20000000);
    bus_wr(3, 32'h20000000); bus_rd(3, d); chk(d == 0, "R9 write 1 clears", d, 0);

    summary();
  end
endmodule